// File: doc/BRIEF.md
# Fractional-Rate PWM Channel Bank

This block produces one pulse-width-modulated output for each of a number of identical channels. Every channel owns one 32-bit control word on a plain read/write port. The output period is not set by a terminal count. Instead, a 16-bit phase accumulator adds a programmable increment on every clock. A wrap of that accumulator marks the end of one output period, so the period is 65536 divided by the increment, in clocks. The duty is set by an 8-bit threshold that runs in the opposite sense to the high time: the output is high while the accumulator's top byte is above the threshold.

Software writes the timing fields into a shadow copy. A write that also sets the update-request bit marks the shadow as pending. The pending values move into the live settings only at a period boundary, so a period never runs with mixed settings. The request bit reads back as 1 until hardware has applied the values. The enable bit is written together with the timing fields, and software changes it on its own by read-modify-write. A disabled channel, or one whose live increment is zero, runs no period, so a pending update applies at the next clock edge.

Top module: `fpwm_bank`

## Requirements
- R1: After reset every control word reads as zero, the accumulators are zero and every output is low.
- R2: Control word layout: bit 31 enable, bit 30 update request (pending flag when read), bits 23:8 increment, bits 7:0 threshold. Bits 29:24 read as zero. A read returns the shadow timing fields.
- R3: Channel k decodes only at byte address k*0x400. A write to any other address changes nothing, and a read from such an address returns zero.
- R4: While a channel is enabled, its accumulator adds the live increment on every clock, modulo 65536. With an increment of 0x1000 the output period is 16 clocks.
- R5: An output is high exactly when its channel is enabled and the accumulator's upper byte is greater than the live threshold.
- R6: A write with the update bit clear changes only the shadow fields and the enable bit. The live increment and threshold, and therefore the output waveform, stay as they were.
- R7: A write with the update bit set makes the pending flag read 1. At the next period boundary (accumulator carry-out) the shadow fields become live and the flag clears.
- R8: While a channel is disabled its accumulator is held at zero and its output is low. A pending update on a disabled channel, or on a channel whose live increment is zero, applies at the next clock edge.
- R9: A write with the update bit clear does not cancel an update that is already pending.
- R10: When a write with the update bit set lands on the same edge as a boundary, the boundary applies the shadow values held before the write, and the flag stays set for the newly written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed control word |
| bus_addr | input | ADDR_W | Byte address; channel slot in bits ADDR_W-1:STRIDE_SHIFT |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read of the addressed control word |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
A write lands at the clock edge on which the strobe is sampled. The new enable bit, the shadow fields and the pending flag are visible on the read port from that edge on. Live values change at the first boundary edge after that. The accumulator's new value, and so the output, reflects them from the edge after. The bench drives inputs just after a rising edge and updates its behavioural model on the same edge the design uses. It compares every output and the read data at the following falling edge, so each result is judged in the cycle it is due. Directed checks count high cycles over whole numbers of periods, so they do not depend on the phase.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam int WORD_W  = 32;
  localparam int INC_W   = 16;
  localparam int THR_W   = 8;
  localparam int EN_POS  = 31;
  localparam int UPD_POS = 30;
  localparam int INC_LSB = 8;
  localparam int THR_LSB = 0;

  typedef struct packed {
    logic [INC_W-1:0] inc;
    logic [THR_W-1:0] thr;
  } fpwm_timing_t;
endpackage

// File: rtl/fpwm_rst_sync.sv
module fpwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl
  import fpwm_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         wr_en_i,
  input  logic         wr_upd_i,
  input  fpwm_timing_t wr_tim_i,
  input  logic         boundary_i,
  output logic         en_o,
  output logic         pend_o,
  output fpwm_timing_t shadow_o,
  output fpwm_timing_t live_o
);
  logic         en_q, en_d;
  logic         pend_q, pend_d;
  fpwm_timing_t shadow_q, shadow_d;
  fpwm_timing_t live_q, live_d;
  logic         apply;

  assign apply = boundary_i && pend_q;

  always_comb begin
    en_d     = en_q;
    pend_d   = pend_q;
    shadow_d = shadow_q;
    live_d   = live_q;
    if (apply) begin
      live_d = shadow_q;
      pend_d = 1'b0;
    end
    if (wr_i) begin
      en_d     = wr_en_i;
      shadow_d = wr_tim_i;
      if (wr_upd_i) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (wr_i)         en_q     <= en_d;
      if (wr_i)         shadow_q <= shadow_d;
      if (wr_i || apply) pend_q  <= pend_d;
      if (apply)        live_q   <= live_d;
    end
  end

  assign en_o     = en_q;
  assign pend_o   = pend_q;
  assign shadow_o = shadow_q;
  assign live_o   = live_q;

  // R7: the pending flag only drops at a boundary
  assert_pend_clear_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(boundary_i));
  // R6: live settings move only when a pending update meets a boundary
  assert_live_only_on_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_q) |-> $past(boundary_i && pend_q));
  // R9: a write without the request never drops the flag by itself
  assert_no_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !boundary_i) |=> pend_q);
endmodule

// File: rtl/fpwm_phase.sv
module fpwm_phase #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, inc_i};

  always_comb begin
    acc_d = '0;
    if (en_i) acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o  = acc_q;
  assign wrap_o = en_i && sum[ACC_W];

  // R4: successive enabled cycles advance by the previous increment
  assert_acc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> acc_q == ACC_W'($past(acc_q) + $past(inc_i)));
  // R8: a disabled cycle leaves the accumulator at zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> acc_q == '0);
endmodule

// File: rtl/fpwm_cmp.sv
module fpwm_cmp #(
  parameter int THR_W = 8
) (
  input  logic             en_i,
  input  logic [THR_W-1:0] phase_hi_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             out_o
);
  assign out_o = en_i && (phase_hi_i > thr_i);
endmodule

// File: rtl/fpwm_bank.sv
module fpwm_bank
  import fpwm_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int STRIDE_SHIFT = 10,
  parameter int ADDR_W       = 12,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int SLOT_W = ADDR_W - STRIDE_SHIFT;
  localparam int ACC_W  = INC_W;

  logic              rst_int_n;
  logic              off_ok;
  logic [SLOT_W-1:0] slot;
  logic [NUM_CH-1:0] ch_sel;
  logic [NUM_CH-1:0] ch_en;
  logic [31:0]       ch_word [NUM_CH];
  fpwm_timing_t      wr_tim;
  logic              unused_rsvd;

  fpwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  assign off_ok      = (bus_addr[STRIDE_SHIFT-1:0] == '0);
  assign slot        = bus_addr[ADDR_W-1:STRIDE_SHIFT];
  assign wr_tim.inc  = bus_wdata[INC_LSB +: INC_W];
  assign wr_tim.thr  = bus_wdata[THR_LSB +: THR_W];
  assign unused_rsvd = ^bus_wdata[29:24];

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic             pend;
    logic             wrap;
    logic             boundary;
    logic [ACC_W-1:0] acc;
    fpwm_timing_t     shadow;
    fpwm_timing_t     live;

    assign ch_sel[k] = off_ok && (slot == SLOT_W'(k));
    assign boundary  = !ch_en[k] || wrap || (live.inc == '0);

    fpwm_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .wr_i       (bus_wr && ch_sel[k]),
      .wr_en_i    (bus_wdata[EN_POS]),
      .wr_upd_i   (bus_wdata[UPD_POS]),
      .wr_tim_i   (wr_tim),
      .boundary_i (boundary),
      .en_o       (ch_en[k]),
      .pend_o     (pend),
      .shadow_o   (shadow),
      .live_o     (live)
    );

    fpwm_phase #(.ACC_W(ACC_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .en_i   (ch_en[k]),
      .inc_i  (live.inc),
      .acc_o  (acc),
      .wrap_o (wrap)
    );

    fpwm_cmp #(.THR_W(THR_W)) u_cmp (
      .en_i       (ch_en[k]),
      .phase_hi_i (acc[ACC_W-1 -: THR_W]),
      .thr_i      (live.thr),
      .out_o      (pwm_out[k])
    );

    always_comb begin
      ch_word[k]                    = '0;
      ch_word[k][EN_POS]            = ch_en[k];
      ch_word[k][UPD_POS]           = pend;
      ch_word[k][INC_LSB +: INC_W]  = shadow.inc;
      ch_word[k][THR_LSB +: THR_W]  = shadow.thr;
    end

    // R8: a channel that was just switched off restarts from a zero phase
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
      $fell(ch_en[k]) |=> acc == '0);
    // R5: the output never rises while the channel is off
    assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
      !ch_en[k] |-> !pwm_out[k]);
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_sel[k]) bus_rdata = ch_word[k];
    end
  end

  // R2: reserved field of any read is zero
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rdata[29:24] == 6'd0);
  // R3: at most one channel decodes any address
  assert_one_slot_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(ch_sel));
endmodule

// File: tb/fpwm_bank_tb.sv
`timescale 1ns/1ps
module fpwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0;
  int n_fail = 0;
  bit model_on = 1'b0;

  int m_en[NCH], m_pd[NCH], m_sb[NCH], m_sd[NCH], m_lb[NCH], m_ld[NCH], m_acc[NCH];

  fpwm_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int c;
    logic [31:0] w;
    w = '0;
    c = a / 1024;
    if ((a % 1024) == 0 && c < NCH) begin
      w[31] = m_en[c][0];
      w[30] = m_pd[c][0];
      w[23:8] = m_sb[c][15:0];
      w[7:0] = m_sd[c][7:0];
    end
    return w;
  endfunction

  function automatic bit model_out(input int c);
    return m_en[c] != 0 && ((m_acc[c] >> 8) > m_ld[c]);
  endfunction

  // Behavioural reference, updated on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_pd[c] = 0; m_sb[c] = 0; m_sd[c] = 0;
        m_lb[c] = 0; m_ld[c] = 0; m_acc[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit bnd;
        int nacc;
        bnd  = (m_en[c] == 0) || (m_lb[c] == 0) || (m_acc[c] + m_lb[c] >= 65536);
        nacc = (m_en[c] != 0) ? (m_acc[c] + m_lb[c]) % 65536 : 0;
        if (bnd && m_pd[c] != 0) begin
          m_lb[c] = m_sb[c]; m_ld[c] = m_sd[c]; m_pd[c] = 0;
        end
        m_acc[c] = nacc;
        if (bus_wr && bus_addr == 12'(c * 1024)) begin
          m_en[c] = int'(bus_wdata[31]);
          m_sb[c] = int'(bus_wdata[23:8]);
          m_sd[c] = int'(bus_wdata[7:0]);
          if (bus_wdata[30]) m_pd[c] = 1;
        end
      end
    end
  end

  // Per-cycle comparison of every output and of the read port
  always @(negedge clk) begin
    if (model_on) begin
      for (int c = 0; c < NCH; c++) check("R5", $sformatf("pwm_out[%0d]", c), pwm_out[c], model_out(c));
      check("R7", "read port", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_at(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = 12'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic count_high(input int c, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[c]) hi++;
    end
  endtask

  function automatic logic [31:0] word(input bit en, input bit upd, input int inc, input int thr);
    return {en, upd, 6'b0, 16'(inc), 8'(thr)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      rd_at(c * 1024, d);
      check("R1", "word after reset", d, 0);
    end
    check("R1", "outputs after reset", pwm_out, 0);
    model_on = 1'b1;

    // R4/R5: increment 0x1000 -> 16-clock period, threshold 0x7F -> 8 of 16 high
    wr(0, word(1, 1, 16'h1000, 8'h7F));
    repeat (4) @(posedge clk);
    count_high(0, 64, hi);
    check("R4", "high count thr 7F", hi, 32);

    // R6: shadow write without request leaves the waveform
    wr(0, word(1, 0, 16'h1000, 8'h3F));
    rd_at(0, d);
    check("R6", "shadow thr readback", d[7:0], 8'h3F);
    check("R2", "pending bit clear", d[30], 0);
    check("R2", "reserved bits", d[29:24], 0);
    count_high(0, 64, hi);
    check("R6", "waveform unchanged", hi, 32);

    // R7: request sets the flag, boundary applies and clears it
    wr(0, word(1, 1, 16'h1000, 8'h3F));
    rd_at(0, d);
    check("R7", "pending after request", d[30], 1);
    repeat (20) @(posedge clk);
    rd_at(0, d);
    check("R7", "pending cleared", d[30], 0);
    count_high(0, 64, hi);
    check("R7", "high count thr 3F", hi, 48);

    // R8: disable holds output low; disabled channel applies update at once
    wr(0, word(0, 0, 16'h1000, 8'h3F));
    count_high(0, 32, hi);
    check("R8", "disabled output", hi, 0);
    wr(1024, word(0, 1, 16'h2000, 8'h10));
    rd_at(1024, d);
    check("R8", "disabled update applied", d[30], 0);
    wr(0, word(1, 0, 16'h1000, 8'h3F));
    repeat (3) @(posedge clk);
    count_high(0, 64, hi);
    check("R8", "re-enabled count", hi, 48);

    // R9: slow channel, request then a plain write; flag must persist
    wr(3072, word(1, 1, 16'h0100, 8'h80));
    repeat (3) @(posedge clk);
    wr(3072, word(1, 1, 16'h0100, 8'h40));
    wr(3072, word(1, 0, 16'h0100, 8'h40));
    rd_at(3072, d);
    check("R9", "pending survives plain write", d[30], 1);

    // R3: stride decode, misaligned address ignored and reads zero
    wr(1024 + 4, word(1, 1, 16'h7777, 8'h55));
    rd_at(1024 + 4, d);
    check("R3", "misaligned read", d, 0);
    rd_at(1024, d);
    check("R3", "channel 1 untouched", d, word(0, 0, 16'h2000, 8'h10));
    rd_at(3072, d);
    check("R3", "channel 3 slot", d[23:8], 16'h0100);

    // R10: back-to-back requests on a 2-clock period channel
    wr(2048, word(1, 1, 16'h8000, 8'h00));
    repeat (4) @(posedge clk);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 12'd2048; bus_wdata = word(1, 1, 16'h8002, 8'h20);
    @(posedge clk); #1;
    bus_wdata = word(1, 1, 16'h8000, 8'h30);
    @(posedge clk); #1;
    bus_wr = 1'b0;
    @(negedge clk);
    check("R10", "flag held after coinciding write", bus_rdata[30], 1);
    repeat (4) @(posedge clk);
    rd_at(2048, d);
    check("R10", "flag cleared later", d[30], 0);

    // Random traffic; the per-cycle model comparison covers R10 collisions
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      bus_wr = ($urandom_range(0, 3) == 0);
      bus_addr = 12'($urandom_range(0, 3) * 1024 + (($urandom_range(0, 7) == 0) ? 4 : 0));
      case ($urandom_range(0, 3))
        0: bus_wdata = word($urandom_range(0, 5) != 0, $urandom_range(0, 1), 16'h1000, $urandom_range(0, 255));
        1: bus_wdata = word($urandom_range(0, 5) != 0, $urandom_range(0, 1), 16'h8002, $urandom_range(0, 255));
        2: bus_wdata = word($urandom_range(0, 5) != 0, $urandom_range(0, 1), $urandom_range(0, 32770), $urandom_range(0, 255));
        default: bus_wdata = $urandom();
      endcase
    end
    @(posedge clk); #1 bus_wr = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule